// File: doc/BRIEF.md
# Register-Programmed Prescaled PWM Generator

This block produces one pulse-width-modulated output from a free-running base tick. Software programs it through a small byte-wide register port: a control register holds an output-enable bit together with a seven-bit prescaler code, a duty register holds an eight-bit level, and a third register holds a separate backlight gate bit. The prescaler divides the base tick by code plus one. Each divided tick advances an eight-bit period counter, and the counter is compared against the active duty level.

The output is high while the counter is below the active level. It is forced high at the full-scale level 255 and stays low at level 0. The output is gated by both the enable bit and the backlight bit, and it comes from a register so that it cannot glitch. A duty level written while the output runs is held in a shadow and applied at the next period boundary. While the output is disabled, both counters are held at zero, so enabling always starts a clean period. Software is expected to clear the control register before it changes the prescaler code.

Top module: `pwmgen_top`

## Requirements
- R1: After a synchronous active-high reset, all three registers read 0 and `pwm_out` is low.
- R2: The control register at address 0x4B reads back exactly as written. Bit 7 is the output enable and bits 6:0 are the prescaler code.
- R3: The duty register at 0x4E reads back all eight bits. The backlight register at 0x51 keeps only bit 0 and reads back 0 in bits 7:1.
- R4: Reads of any other address return 0. Writes to any other address change no register.
- R5: With prescaler code c, the period counter advances once every c+1 base ticks, and one period lasts 256×(c+1) base ticks.
- R6: Over one period, the output is high for level×(c+1) base ticks when the level is below 255. At level 255 it is high for the whole period, and at level 0 it stays low.
- R7: Clock cycles in which `base_tick` is low do not advance the prescaler. Timing is counted in base ticks, not in clock cycles.
- R8: `pwm_out` is low whenever the enable bit is 0 or the backlight bit is 0.
- R9: A duty level written while enabled takes effect only after the counter wraps from 255 to 0. A level written while disabled is applied immediately.
- R10: When the enable bit goes from 0 to 1, both counters start from zero. With code 0 and a continuous tick, the output rises on the clock after the enabling write and stays high for exactly `level` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Base clock enable strobe that feeds the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for read and write |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pwm_out | output | 1 | Gated PWM output, active high |

## Verification
The hardest case to reach from the ports is a duty write that lands in the middle of a running period. The bench must show that the old level stays in force until the wrap, not merely that the new level eventually appears. To get there, the bench enables the output with level 0 and a known phase. It writes a new level about twenty counts into the period and confirms the output stays low for the rest of that period. It then measures the new level over a later full period. The restart on enable is pinned the same way: the bench counts the high cycles in fixed windows measured from the enabling write.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int PRE_W  = 7;
    localparam int CNT_W  = 8;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 8'h4B;
    localparam logic [ADDR_W-1:0] ADR_DUTY = 8'h4E;
    localparam logic [ADDR_W-1:0] ADR_BLEN = 8'h51;

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] code;
    } ctrl_t;

    function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
        return (a == ADR_CTRL) || (a == ADR_DUTY) || (a == ADR_BLEN);
    endfunction
endpackage

// File: rtl/pwmgen_regs.sv
module pwmgen_regs
    import pwmgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  duty,
    output logic              blen,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            duty <= '0;
            blen <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                ADR_CTRL: ctrl <= ctrl_t'(wdata);
                ADR_DUTY: duty <= wdata[CNT_W-1:0];
                ADR_BLEN: blen <= wdata[0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: rdata = DATA_W'(ctrl);
            ADR_DUTY: rdata = DATA_W'(duty);
            ADR_BLEN: rdata = DATA_W'(blen);
            default:  rdata = '0;
        endcase
    end

    AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_CTRL) |=> (ctrl == ctrl_t'($past(wdata)))); // R2

    AST_UNMAPPED_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr_mapped(addr)) |=> ($stable(ctrl) && $stable(duty) && $stable(blen))); // R4

    always_comb begin
        if (!rst && !addr_mapped(addr))
            AST_UNMAPPED_ZERO: assert (rdata == '0); // R4
    end
endmodule

// File: rtl/pwmgen_presc.sv
module pwmgen_presc #(
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             base_tick,
    input  logic [PRE_W-1:0] code,
    output logic             div_tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic             wrap;

    assign wrap     = (pre_cnt >= code);
    assign div_tick = run && base_tick && wrap;

    always_ff @(posedge clk) begin
        if (rst || !run)
            pre_cnt <= '0;
        else if (base_tick)
            pre_cnt <= wrap ? '0 : pre_cnt + 1'b1;
    end

    AST_TICK_NEEDS_BASE: assert property (@(posedge clk) disable iff (rst)
        div_tick |-> (base_tick && run)); // R7

    AST_PRE_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_cnt == '0)); // R10
endmodule

// File: rtl/pwmgen_core.sv
module pwmgen_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             gate,
    input  logic             div_tick,
    input  logic [CNT_W-1:0] duty_req,
    output logic             pwm_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] duty_act;
    logic             raw;
    logic             boundary;

    assign boundary = div_tick && (cnt == CNT_MAX);
    assign raw      = (duty_act == CNT_MAX) || (cnt < duty_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            duty_act <= '0;
            pwm_out  <= 1'b0;
        end else begin
            if (!run) begin
                cnt      <= '0;
                duty_act <= duty_req;
            end else if (div_tick) begin
                cnt <= cnt + 1'b1;
                if (boundary)
                    duty_act <= duty_req;
            end
            pwm_out <= run && gate && raw;
        end
    end

    AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
        pwm_out |-> $past(run && gate)); // R8

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !boundary) |=> $stable(duty_act)); // R9

    AST_CNT_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0)); // R10
endmodule

// File: rtl/pwmgen_top.sv
module pwmgen_top
    import pwmgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              base_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] duty;
    logic             blen;
    logic             div_tick;

    pwmgen_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .ctrl  (ctrl),
        .duty  (duty),
        .blen  (blen),
        .rdata (rdata)
    );

    pwmgen_presc #(.PRE_W(PRE_W)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.run),
        .base_tick (base_tick),
        .code      (ctrl.code),
        .div_tick  (div_tick)
    );

    pwmgen_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .gate     (blen),
        .div_tick (div_tick),
        .duty_req (duty),
        .pwm_out  (pwm_out)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !pwm_out); // R1
endmodule

// File: tb/tb_pwmgen_top.sv
module tb_pwmgen_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pwm_out;

    int n_checks = 0;
    int n_fail = 0;
    int hi = 0;
    logic tick_alt = 1'b0;

    always #2 clk = ~clk;

    pwmgen_top dut (
        .clk(clk), .rst(rst), .base_tick(base_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    // {alternate tick, prescaler code, level}
    localparam logic [15:0] VEC [8] = '{
        {1'b0, 7'd0, 8'd64},
        {1'b0, 7'd0, 8'd200},
        {1'b0, 7'd1, 8'd100},
        {1'b0, 7'd3, 8'd37},
        {1'b1, 7'd0, 8'd90},
        {1'b0, 7'd2, 8'd255},
        {1'b0, 7'd0, 8'd0},
        {1'b1, 7'd1, 8'd1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (pwm_out) hi++;
        base_tick = tick_alt ? ~base_tick : 1'b1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc();
        wr_en = 1'b1; addr = a; wdata = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    initial begin
        #700000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int v;
        run(3);
        rst = 1'b0;
        run(2);
        // R1 reset state
        rd(8'h4B, v); chk("R1 ctrl", v, 0);
        rd(8'h4E, v); chk("R1 duty", v, 0);
        rd(8'h51, v); chk("R1 blen", v, 0);
        chk("R1 out", int'(pwm_out), 0);

        // R2 control readback
        wr(8'h4B, 8'hE3); rd(8'h4B, v); chk("R2 ctrl E3", v, 8'hE3);
        wr(8'h4B, 8'h00); rd(8'h4B, v); chk("R2 ctrl 00", v, 0);
        // R3 duty and backlight readback
        wr(8'h4E, 8'hA5); rd(8'h4E, v); chk("R3 duty", v, 8'hA5);
        wr(8'h51, 8'hFF); rd(8'h51, v); chk("R3 blen", v, 1);
        // R4 unmapped
        wr(8'h4C, 8'h77); rd(8'h4C, v); chk("R4 read 4C", v, 0);
        rd(8'h00, v); chk("R4 read 00", v, 0);
        rd(8'h4B, v); chk("R4 ctrl kept", v, 0);
        rd(8'h4E, v); chk("R4 duty kept", v, 8'hA5);

        // R5 R6 R7 vector walk
        for (int k = 0; k < 8; k++) begin
            int code, lvl, mul, win, exp_hi;
            tick_alt = VEC[k][15];
            code = int'(VEC[k][14:8]);
            lvl  = int'(VEC[k][7:0]);
            mul  = (code + 1) * (tick_alt ? 2 : 1);
            win  = 256 * mul;
            exp_hi = (lvl == 255) ? win : lvl * mul;
            wr(8'h4B, 8'h00);
            wr(8'h4E, 8'(lvl));
            wr(8'h4B, {1'b1, 7'(code)});
            run(2 * win);
            hi = 0;
            run(win);
            chk($sformatf("R5 R6 R7 vec%0d", k), hi, exp_hi);
        end
        tick_alt = 1'b0;

        // R8 gating
        wr(8'h4B, 8'h00); wr(8'h4E, 8'd128); wr(8'h51, 8'h00); wr(8'h4B, 8'h80);
        run(300); hi = 0; run(256); chk("R8 blen off", hi, 0);
        wr(8'h51, 8'h01); wr(8'h4B, 8'h00);
        hi = 0; run(256); chk("R8 enable off", hi, 0);

        // R10 restart phase
        wr(8'h4B, 8'h80);
        hi = 0; run(100); chk("R10 early high", hi, 100);
        run(39);
        hi = 0; run(110); chk("R10 late low", hi, 0);

        // R9 shadow duty
        wr(8'h4B, 8'h00); wr(8'h4E, 8'd0); wr(8'h4B, 8'h80);
        run(20);
        wr(8'h4E, 8'd200);
        hi = 0; run(150); chk("R9 old level held", hi, 0);
        run(600);
        hi = 0; run(256); chk("R9 new level", hi, 200);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule